// File: doc/BRIEF.md
# Cycle-Counting Interval Timer

A one-shot down-counter that measures intervals in CPU bus cycles. It advances only on cycles where the CPU clock-enable input is high, so the interval does not depend on the speed of the fast system clock. Internally the counter is 12 bits. Software sees only its top 8 bits, so one visible count step equals 16 enabled cycles.

Software talks to the timer through two byte registers at adjacent addresses:

- **Count register (address 0).** A write sets the preset in the top 8 bits and fills the 4 hidden low bits with ones. A read returns the live top 8 bits.
- **Control register (address 1).** It holds a run flag and an interrupt-enable flag.

Once started, the counter runs down to zero. One enabled cycle later it stops by itself. If interrupts are enabled, it also raises an interrupt request, which stays high until software acknowledges it.

Top module: `cycle_timer`

## Requirements
- R1: After reset, the count register reads 0x00, the control register reads 0x00 and `irq` is low.
- R2: Writing value N to address 0 sets the counter to N*16+15. Reading address 0 returns counter bits 11..4, so it reads N right after the write.
- R3: The counter decrements by one on each clock edge where `cycleEn` is high and the run flag is set. Otherwise it holds its value.
- R4: With preset N and a continuous or sparse `cycleEn` pattern, the run flag clears after exactly (N+1)*16 enabled cycles. The count then holds at zero.
- R5: Writing 1 to control bit 0 starts the counter, and bit 0 reads 1 for as long as it is running. Starting with a count of zero stops it on the first enabled cycle.
- R6: When the run ends, `irq` goes high on the next cycle if control bit 7 was 1. If bit 7 was 0, `irq` stays low. Bit 7 reads back as written.
- R7: Once high, `irq` stays high until a write to address 1 or a read of address 0 (`rdEn` with `sel`). Neither action clears it if it coincides with a run ending.
- R8: Writing 0 to control bit 0 while running stops the count, and the count holds its value.
- R9: Writing address 0 while running reloads the counter and leaves the run flag set.
- R10: Control bits 6..1 read 0 regardless of what is written to them.
- R11: Accesses with `sel` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | One pulse per CPU bus cycle |
| sel | input | 1 | Register select |
| addr | input | 1 | 0 = count register, 1 = control register |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe, used only for acknowledging the interrupt |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register `addr` selects, combinational |
| irq | output | 1 | Terminal-count interrupt request |

## Verification
A wrong hidden low nibble shows up only as a shifted stop point. The run would end one or more cycles away from (N+1)*16, while every visible count looks plausible for up to 15 cycles. For that reason the bench counts enabled cycles to the exact edge where the run flag drops. It also compares the visible count after every enabled cycle, so a faulty decrement or hold is caught within one visible step of 16 cycles. A wrong acknowledge or enable path appears on `irq` on the cycle after the run ends or after the acknowledging access.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic load;
    logic dec;
  } dpStrobe_t;
endpackage

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int VIS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VIS_W-1:0] presetIn,
  output logic [CNT_W-1:0] cnt,
  output logic             isZero
);
  localparam int LOW_W = CNT_W - VIS_W;

  always_ff @(posedge clk) begin
    if (!rstN)
      cnt <= '0;
    else if (strobe.load)
      cnt <= {presetIn, {LOW_W{1'b1}}};
    else if (strobe.dec)
      cnt <= cnt - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign isZero = (cnt == '0);
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic              sel,
  input  logic              addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntZero,
  output dpStrobe_t         strobe,
  output logic              runQ,
  output logic              irqEnQ,
  output logic              irqQ
);
  localparam int RUN_BIT = 0;
  localparam int IEN_BIT = DATA_W - 1;

  logic wrCnt, wrCtl, rdCnt, tick, terminal;

  assign wrCnt    = sel & wrEn & ~addr;
  assign wrCtl    = sel & wrEn & addr;
  assign rdCnt    = sel & rdEn & ~addr;
  assign tick     = runQ & cycleEn;
  assign terminal = tick & cntZero;

  always_comb begin
    strobe      = '0;
    strobe.load = wrCnt;
    strobe.dec  = tick & ~cntZero & ~wrCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      irqEnQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (wrCtl) begin
        runQ   <= wrData[RUN_BIT];
        irqEnQ <= wrData[IEN_BIT];
      end else if (terminal) begin
        runQ <= 1'b0;
      end
      if (terminal && irqEnQ)
        irqQ <= 1'b1;
      else if (wrCtl || rdCnt)
        irqQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int VIS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleEn,
  input  logic             sel,
  input  logic             addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [VIS_W-1:0] wrData,
  output logic [VIS_W-1:0] rdData,
  output logic             irq
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cnt;
  logic             cntZero, runQ, irqEnQ;
  logic [VIS_W-1:0] ctlWord;

  timer_ctrl #(.DATA_W(VIS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .sel(sel), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .cntZero(cntZero),
    .strobe(strobe), .runQ(runQ), .irqEnQ(irqEnQ), .irqQ(irq)
  );

  timer_dp #(.CNT_W(CNT_W), .VIS_W(VIS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .presetIn(wrData),
    .cnt(cnt), .isZero(cntZero)
  );

  always_comb begin
    ctlWord          = '0;
    ctlWord[VIS_W-1] = irqEnQ;
    ctlWord[0]       = runQ;
  end

  assign rdData = addr ? ctlWord : cnt[CNT_W-1 -: VIS_W];
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
  parameter int CNT_W = 12,
  parameter int VIS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleEn,
  input logic             sel,
  input logic             addr,
  input logic             wrEn,
  input logic             rdEn,
  input logic [VIS_W-1:0] wrData,
  input logic [VIS_W-1:0] rdData,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             runQ,
  input logic             irqEnQ
);
  localparam int LOW_W = CNT_W - VIS_W;

  logic cntWr, ctlWr, endNow;
  assign cntWr  = sel && wrEn && !addr;
  assign ctlWr  = sel && wrEn && addr;
  assign endNow = runQ && cycleEn && (cnt == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cnt == {$past(wrData), {LOW_W{1'b1}}});

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleEn && !cntWr) |=> $stable(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && cycleEn && cnt != '0 && !cntWr)
      |=> cnt == $past(cnt) - {{(CNT_W-1){1'b0}}, 1'b1});

  p_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (endNow && !ctlWr) |=> !runQ);

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(irqEnQ) && $past(cnt) == '0));

  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sel && ((wrEn && addr) || (rdEn && !addr)) && !endNow) |=> !irq);

  p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    addr |-> rdData[VIS_W-2:1] == '0);
endmodule

bind cycle_timer cycle_timer_chk #(.CNT_W(CNT_W), .VIS_W(VIS_W)) u_chk (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .sel(sel), .addr(addr),
  .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq),
  .cnt(cnt), .runQ(runQ), .irqEnQ(irqEnQ)
);

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleEn = 1'b0;
  logic       sel = 1'b0;
  logic       addr = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cycle_timer u_dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .sel(sel), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; sel = 1'b0;
  endtask

  task automatic peek(input logic a, output int v);
    sel = 1'b1; addr = a; #1;
    v = int'(rdData);
    sel = 1'b0;
  endtask

  task automatic ackRead();
    @(negedge clk);
    sel = 1'b1; addr = 1'b0; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; sel = 1'b0;
  endtask

  task automatic idle(input int n);
    cycleEn = 1'b1;
    repeat (n) @(negedge clk);
    cycleEn = 1'b0;
  endtask

  // Full run: preset n, interrupt enable ie, cycleEn asserted on every 'gap'-th cycle.
  task automatic runOnce(input int n, input bit ie, input int gap);
    int v, c, start, total, step;
    total = (n + 1) * 16;
    start = n * 16 + 15;
    busWrite(1'b0, n[7:0]);
    peek(1'b0, v); check("R2 preset readback", v, n);
    busWrite(1'b1, {ie, 6'b0, 1'b1});
    peek(1'b1, v); check("R5 run reads 1", v, {ie, 7'd1});
    check("R7 irq cleared by control write", int'(irq), 0);
    c = 0; step = 0;
    while (c < total) begin
      cycleEn = ((step % gap) == 0);
      @(posedge clk);
      if (cycleEn) c++;
      step++;
      @(negedge clk);
      cycleEn = 1'b0;
      if (c < total) begin
        peek(1'b0, v);
        check("R3 visible count", v, (start - (c > start ? start : c)) >> 4);
        peek(1'b1, v);
        check("R4 still running", v & 1, 1);
      end
    end
    peek(1'b1, v); check("R4 run clear after (N+1)*16", v & 1, 0);
    peek(1'b0, v); check("R4 count holds zero", v, 0);
    check("R6 irq per enable", int'(irq), int'(ie));
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    peek(1'b0, v); check("R1 count reset", v, 0);
    peek(1'b1, v); check("R1 control reset", v, 0);
    check("R1 irq reset", int'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);
    peek(1'b0, v); check("R1 count after release", v, 0);

    // R5 start from zero: ends on first enabled cycle
    busWrite(1'b1, 8'h81);
    idle(1);
    peek(1'b1, v); check("R5 zero start stops at once", v & 1, 0);
    check("R6 irq after zero start", int'(irq), 1);

    // R7 irq holds, control read does not clear, count read clears
    idle(5);
    peek(1'b1, v);
    check("R7 irq held", int'(irq), 1);
    @(negedge clk); sel = 1'b1; addr = 1'b1; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; sel = 1'b0;
    check("R7 control read keeps irq", int'(irq), 1);
    ackRead();
    check("R7 count read clears irq", int'(irq), 0);

    // R11 unselected accesses ignored
    @(negedge clk); sel = 1'b0; wrEn = 1'b1; addr = 1'b0; wrData = 8'h55;
    @(negedge clk); addr = 1'b1; wrData = 8'hFF;
    @(negedge clk); wrEn = 1'b0;
    peek(1'b0, v); check("R11 count unchanged", v, 0);
    peek(1'b1, v); check("R11 control unchanged", v, 8'h80);

    // R10 padding bits
    busWrite(1'b1, 8'h7E);
    peek(1'b1, v); check("R10 pad bits read zero", v, 0);

    // R3 hold without cycleEn while running
    busWrite(1'b0, 8'h10);
    busWrite(1'b1, 8'h01);
    repeat (20) @(negedge clk);
    peek(1'b0, v); check("R3 hold without cycleEn", v, 8'h10);
    idle(16);
    peek(1'b0, v); check("R3 16 cycles = one step", v, 8'h0F);

    // R9 reload while running
    busWrite(1'b0, 8'h03);
    peek(1'b1, v); check("R9 run kept on reload", v & 1, 1);
    peek(1'b0, v); check("R9 reload value", v, 3);
    idle(63);
    peek(1'b1, v); check("R9 running before end", v & 1, 1);
    idle(1);
    peek(1'b1, v); check("R9 end after 64", v & 1, 0);

    // R8 stop mid-run
    busWrite(1'b0, 8'h20);
    busWrite(1'b1, 8'h01);
    idle(40);
    busWrite(1'b1, 8'h00);
    idle(50);
    peek(1'b0, v); check("R8 count holds after stop", v, (32*16+15-40) >> 4);
    check("R8 no irq", int'(irq), 0);

    // Sweeps (R4, R6)
    for (int n = 0; n < 32; n++) runOnce(n, n[0], 1);
    runOnce(255, 1'b1, 3);
    runOnce(100, 1'b0, 2);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule